// File: doc/BRIEF.md
# GPIO Port with Pin Sense Detection

This block is a general-purpose I/O port with a parameterised number of pins (32 by default). Software reaches it over a simple single-cycle register bus: it sets output levels and directions, reads back the pad levels through a fixed two-stage synchroniser, and gives each pin a configuration word. That word holds the direction, the pull-up and pull-down request bits, an input-buffer connect bit and a sense mode. A pin whose buffer is disconnected reads as 0 and plays no part in sense detection.

Sense detection combines all pins into one level output, `detect`. It rises when any connected pin with sensing enabled is at its active level. It stays high while any such pin remains active. After it falls, the whole port must be quiet for a minimum number of cycles before `detect` can fire again. Another peripheral can take over the output value and direction of any pin through a per-pin override. Pull resistors appear only as control outputs.

Bus map: word 0 is OUT, word 1 is DIR, word 2 is IN (read-only), and words 32 to 63 are the per-pin configuration registers for pins 0 to 31. The configuration word layout is: bit 0 direction (1 = output), bit 1 buffer connect (1 = connected), bit 2 pull-down, bit 3 pull-up, bits 5:4 sense mode.

Top module: `gpio_sense_port`

## Requirements
- R1: After reset, OUT, DIR, IN and every configuration word read 0. Every pin is an input with its buffer disconnected, sense disabled and no pull. `detect` and all `pad_oe` bits are 0.
- R2: A bus write with `bus_sel` and `bus_we` high is stored at the clock edge. Configuration word n (address 32+n) reads back its six bits in the positions given above. Writes to IN (address 2) change nothing. Reads of unmapped words 3 to 31, or with `bus_sel` low, return 0.
- R3: A level on `pad_in[n]` of a connected pin appears in the IN word after exactly two rising clock edges.
- R4: A pin whose connect bit is 0 reads 0 in IN and never causes `detect`, whatever its pad level and sense mode.
- R5: Sense mode 2'b10 makes high the active level and 2'b11 makes low the active level; 2'b00 and 2'b01 disable sensing. When the port is armed, `detect` rises on the clock edge after the IN word first shows an active level on a sensing pin.
- R6: Once high, `detect` stays high while any sensing pin remains active. It falls on the clock edge after the IN word shows every sensing pin inactive.
- R7: After `detect` falls, it can rise again only after 3 consecutive cycles in which every sensing pin is inactive. An active sample inside that window restarts the count. Before the first `detect` after reset, the port is already armed.
- R8: With no override, `pad_out` follows OUT and `pad_oe` follows DIR. DIR bit n and configuration bit 0 of pin n are the same storage, so writing either one updates both views.
- R9: Where `ovr_en[n]` is 1, `pad_out[n]` and `pad_oe[n]` take `ovr_out[n]` and `ovr_oe[n]` instead of the port registers, and they do so in the same cycle.
- R10: `pad_pull_up[n]` and `pad_pull_dn[n]` reflect configuration bits 3 and 2 of pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| pad_pull_up | output | 32 | Pull-up requests |
| pad_pull_dn | output | 32 | Pull-down requests |
| ovr_en | input | 32 | Per-pin peripheral override enable |
| ovr_out | input | 32 | Peripheral output value |
| ovr_oe | input | 32 | Peripheral output enable |
| detect | output | 1 | Port-wide sense level |

## Verification
The bench builds the port with its default values: 32 pins, a two-stage synchroniser and a three-cycle re-arm window. With these values every configuration word is addressable and the exact edge counts of R3, R5, R6 and R7 can be hit in directed cases. A quiet gap of two cycles shows that the re-arm window blocks a new event, and a gap of three cycles shows that it opens. Sparse random pad toggling, combined with random configuration and override traffic, then lets the full-width sense OR race against the re-arm counter.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

  localparam int CFG_W = 6;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_HIGH = 2'b10,
    SENSE_LOW  = 2'b11
  } sense_mode_e;

  // bit layout: [5:4] sense, [3] pull-up, [2] pull-down, [1] connect, [0] dir
  typedef struct packed {
    sense_mode_e sense;
    logic        pull_up;
    logic        pull_dn;
    logic        connect;
    logic        dir;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{
    sense:   SENSE_OFF,
    pull_up: 1'b0,
    pull_dn: 1'b0,
    connect: 1'b0,
    dir:     1'b0
  };

  typedef enum logic [1:0] {
    DET_ARMED  = 2'b00,
    DET_ACTIVE = 2'b01,
    DET_REARM  = 2'b10
  } det_state_e;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_sense_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NUM_PINS-1:0]           bus_wdata,
  input  logic [NUM_PINS-1:0]           in_val,
  output logic [NUM_PINS-1:0]           out_q,
  output pin_cfg_t [NUM_PINS-1:0]       cfg_q,
  output logic [NUM_PINS-1:0]           bus_rdata
);

  localparam int IDX_W = ADDR_W - 1;
  localparam logic [IDX_W-1:0] W_OUT = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_DIR = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_IN  = IDX_W'(2);

  logic                    wr;
  logic                    is_cfg;
  logic [IDX_W-1:0]        idx;
  logic [NUM_PINS-1:0]     out_d;
  logic                    out_en;
  pin_cfg_t [NUM_PINS-1:0] cfg_d;
  logic [NUM_PINS-1:0]     cfg_en;
  logic [NUM_PINS-1:0]     dir_vec;

  assign wr     = bus_sel & bus_we;
  assign is_cfg = bus_addr[ADDR_W-1];
  assign idx    = bus_addr[IDX_W-1:0];

  always_comb begin
    for (int n = 0; n < NUM_PINS; n++) dir_vec[n] = cfg_q[n].dir;
  end

  // next-state
  always_comb begin
    out_d  = out_q;
    out_en = 1'b0;
    cfg_d  = cfg_q;
    cfg_en = '0;
    if (wr && !is_cfg && idx == W_OUT) begin
      out_d  = bus_wdata;
      out_en = 1'b1;
    end
    if (wr && !is_cfg && idx == W_DIR) begin
      for (int n = 0; n < NUM_PINS; n++) cfg_d[n].dir = bus_wdata[n];
      cfg_en = '1;
    end
    if (wr && is_cfg) begin
      cfg_d[idx]  = pin_cfg_t'(bus_wdata[CFG_W-1:0]);
      cfg_en[idx] = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_PINS; n++) cfg_q[n] <= CFG_RESET;
    end else begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (cfg_en[n]) cfg_q[n] <= cfg_d[n];
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (is_cfg) begin
        bus_rdata[CFG_W-1:0] = cfg_q[idx];
      end else if (idx == W_OUT) begin
        bus_rdata = out_q;
      end else if (idx == W_DIR) begin
        bus_rdata = dir_vec;
      end else if (idx == W_IN) begin
        bus_rdata = in_val;
      end
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] conn_vec,
  output logic [NUM_PINS-1:0] in_val
);

  logic [NUM_PINS-1:0] stage_d [SYNC_STAGES];
  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

  always_comb begin
    stage_d[0] = pad_in;
    for (int s = 1; s < SYNC_STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  // a disconnected buffer blocks the read path
  assign in_val = stage_q[SYNC_STAGES-1] & conn_vec;

endmodule

// File: rtl/gpio_sense_detect.sv
module gpio_sense_detect
  import gpio_sense_pkg::*;
#(
  parameter int NUM_PINS     = 32,
  parameter int REARM_CYCLES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] in_val,
  input  logic [NUM_PINS-1:0] conn_vec,
  input  logic [NUM_PINS-1:0] sense_en,
  input  logic [NUM_PINS-1:0] sense_low,
  output logic                any_active,
  output logic                detect
);

  localparam int CNT_W = $clog2(REARM_CYCLES + 1);

  logic [NUM_PINS-1:0] active_vec;
  det_state_e          st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign active_vec[g] = conn_vec[g] & sense_en[g] & (in_val[g] ^ sense_low[g]);
  end

  assign any_active = |active_vec;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      DET_ARMED: begin
        if (any_active) st_d = DET_ACTIVE;
      end
      DET_ACTIVE: begin
        if (!any_active) begin
          st_d  = DET_REARM;
          cnt_d = CNT_W'(1);
        end
      end
      DET_REARM: begin
        if (any_active) begin
          cnt_d = '0;
        end else if (cnt_q == CNT_W'(REARM_CYCLES - 1)) begin
          st_d  = DET_ARMED;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = DET_ARMED;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DET_ARMED;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign detect = (st_q == DET_ACTIVE);

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] out_q,
  input  logic [NUM_PINS-1:0] dir_vec,
  input  logic [NUM_PINS-1:0] ovr_en,
  input  logic [NUM_PINS-1:0] ovr_out,
  input  logic [NUM_PINS-1:0] ovr_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign pad_out[g] = ovr_en[g] ? ovr_out[g] : out_q[g];
    assign pad_oe[g]  = ovr_en[g] ? ovr_oe[g]  : dir_vec[g];
  end

endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
  import gpio_sense_pkg::*;
#(
  parameter int NUM_PINS     = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int REARM_CYCLES = 3,
  parameter int ADDR_W       = $clog2(NUM_PINS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pull_up,
  output logic [NUM_PINS-1:0] pad_pull_dn,
  input  logic [NUM_PINS-1:0] ovr_en,
  input  logic [NUM_PINS-1:0] ovr_out,
  input  logic [NUM_PINS-1:0] ovr_oe,
  output logic                detect
);

  logic [1:0]              rst_pipe_q;
  logic                    rst_sync_n;
  logic [NUM_PINS-1:0]     out_q;
  pin_cfg_t [NUM_PINS-1:0] cfg_q;
  logic [NUM_PINS-1:0]     in_val;
  logic [NUM_PINS-1:0]     conn_vec;
  logic [NUM_PINS-1:0]     dir_vec;
  logic [NUM_PINS-1:0]     sense_en;
  logic [NUM_PINS-1:0]     sense_low;
  logic                    any_active;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cfg
    assign conn_vec[g]    = cfg_q[g].connect;
    assign dir_vec[g]     = cfg_q[g].dir;
    assign pad_pull_up[g] = cfg_q[g].pull_up;
    assign pad_pull_dn[g] = cfg_q[g].pull_dn;
    assign sense_en[g]    = (cfg_q[g].sense == SENSE_HIGH) || (cfg_q[g].sense == SENSE_LOW);
    assign sense_low[g]   = (cfg_q[g].sense == SENSE_LOW);
  end

  gpio_cfg_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .in_val    (in_val),
    .out_q     (out_q),
    .cfg_q     (cfg_q),
    .bus_rdata (bus_rdata)
  );

  gpio_in_sync #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pad_in   (pad_in),
    .conn_vec (conn_vec),
    .in_val   (in_val)
  );

  gpio_sense_detect #(
    .NUM_PINS     (NUM_PINS),
    .REARM_CYCLES (REARM_CYCLES)
  ) u_sense (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_val     (in_val),
    .conn_vec   (conn_vec),
    .sense_en   (sense_en),
    .sense_low  (sense_low),
    .any_active (any_active),
    .detect     (detect)
  );

  gpio_pad_mux #(
    .NUM_PINS (NUM_PINS)
  ) u_mux (
    .out_q   (out_q),
    .dir_vec (dir_vec),
    .ovr_en  (ovr_en),
    .ovr_out (ovr_out),
    .ovr_oe  (ovr_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

endmodule

// File: rtl/gpio_sense_port_sva.sv
module gpio_sense_port_sva #(
  parameter int NUM_PINS     = 32,
  parameter int REARM_CYCLES = 3,
  parameter int ADDR_W       = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] ovr_en,
  input logic [NUM_PINS-1:0] in_val,
  input logic [NUM_PINS-1:0] conn_vec,
  input logic                any_active,
  input logic                detect
);

  localparam int QW = $clog2(REARM_CYCLES + 1);

  logic [1:0]    warm_q;
  logic [QW-1:0] quiet_q;
  logic          armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q  <= 2'd0;
      quiet_q <= '0;
      armed_q <= 1'b1;
    end else begin
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
      if (any_active) quiet_q <= '0;
      else if (quiet_q != QW'(REARM_CYCLES)) quiet_q <= quiet_q + QW'(1);
      if (detect) armed_q <= 1'b0;
      else if (!any_active && quiet_q == QW'(REARM_CYCLES - 1)) armed_q <= 1'b1;
    end
  end

  // R3: synchronised value equals the pad two edges back, masked by connect (R4)
  a_r3_in_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (in_val == ($past(pad_in, 2) & conn_vec)));

  // R5: detect only rises from an active sense sample
  a_r5_detect_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect) |-> $past(any_active));

  // R6: detect holds while a sensing pin stays active
  a_r6_detect_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(detect) && $past(any_active)) |-> detect);

  // R7: a new detect needs a full quiet window since the previous one
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect) |-> $past(armed_q));

  // R8: non-overridden pads follow a written OUT word
  a_r8_out_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(0))
      |=> (((pad_out ^ $past(bus_wdata)) & ~ovr_en) == '0));

endmodule

bind gpio_sense_port gpio_sense_port_sva #(
  .NUM_PINS     (NUM_PINS),
  .REARM_CYCLES (REARM_CYCLES),
  .ADDR_W       (ADDR_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .ovr_en     (ovr_en),
  .in_val     (in_val),
  .conn_vec   (conn_vec),
  .any_active (any_active),
  .detect     (detect)
);

// File: tb/gpio_sense_port_tb.sv
`timescale 1ns/1ps
module gpio_sense_port_tb;

  localparam int NP = 32;
  localparam int AW = 6;

  logic          clk, rst_n, bus_sel, bus_we;
  logic [AW-1:0] bus_addr;
  logic [NP-1:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic [NP-1:0] pad_pull_up, pad_pull_dn, ovr_en, ovr_out, ovr_oe;
  logic          detect;

  int checks = 0;
  int fails  = 0;

  gpio_sense_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .ovr_en(ovr_en), .ovr_out(ovr_out), .ovr_oe(ovr_oe), .detect(detect)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model, from the requirements ----------------
  logic [NP-1:0] m_out, m_s1, m_s2;
  logic [5:0]    m_cfg [NP];
  logic          m_det;
  logic [1:0]    m_quiet;

  function automatic logic [NP-1:0] m_conn();
    for (int n = 0; n < NP; n++) m_conn[n] = m_cfg[n][1];
  endfunction

  function automatic logic [NP-1:0] m_dirv();
    for (int n = 0; n < NP; n++) m_dirv[n] = m_cfg[n][0];
  endfunction

  function automatic logic m_act();
    logic a = 1'b0;
    for (int n = 0; n < NP; n++)
      if (m_cfg[n][1] && m_cfg[n][5] && (m_s2[n] ^ m_cfg[n][4])) a = 1'b1;
    return a;
  endfunction

  function automatic logic [NP-1:0] m_read(logic [AW-1:0] a);
    if (a[5]) return {26'b0, m_cfg[a[4:0]]};
    if (a == 6'd0) return m_out;
    if (a == 6'd1) return m_dirv();
    if (a == 6'd2) return m_s2 & m_conn();
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out <= '0; m_s1 <= '0; m_s2 <= '0; m_det <= 1'b0; m_quiet <= 2'd3;
      for (int n = 0; n < NP; n++) m_cfg[n] <= 6'd0;
    end else begin
      if (bus_sel && bus_we) begin
        if (bus_addr[5]) m_cfg[bus_addr[4:0]] <= bus_wdata[5:0];
        else if (bus_addr == 6'd0) m_out <= bus_wdata;
        else if (bus_addr == 6'd1)
          for (int n = 0; n < NP; n++) m_cfg[n][0] <= bus_wdata[n];
      end
      m_s1 <= pad_in;
      m_s2 <= m_s1;
      if (m_det) begin
        if (!m_act()) begin m_det <= 1'b0; m_quiet <= 2'd1; end
      end else if (m_act()) begin
        if (m_quiet == 2'd3) m_det <= 1'b1;
        m_quiet <= 2'd0;
      end else if (m_quiet != 2'd3) begin
        m_quiet <= m_quiet + 2'd1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NP-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [NP-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NP-1:0] v;
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; ovr_en = '0; ovr_out = '0; ovr_oe = '0;
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    rd(6'd0, v);  chk("R1 OUT", v, '0);
    rd(6'd1, v);  chk("R1 DIR", v, '0);
    rd(6'd32, v); chk("R1 CFG0", v, '0);
    cyc();
    rd(6'd63, v); chk("R1 CFG31", v, '0);
    chk("R1 detect", {31'b0, detect}, '0);
    chk("R1 pad_oe", pad_oe, '0);

    // R2 config readback, IN write ignored, unmapped read
    wr(6'd37, 32'h2E);
    rd(6'd37, v); chk("R2 CFG5 readback", v, 32'h2E);
    wr(6'd2, 32'hFFFF_FFFF);
    rd(6'd2, v);  chk("R2 IN write ignored", v, '0);
    cyc();
    rd(6'd3, v);  chk("R2 unmapped", v, '0);

    // R10 pull bits
    wr(6'd37, 32'h26);
    wr(6'd38, 32'h0A);
    chk("R10 pull_up", pad_pull_up, 32'h0000_0040);
    chk("R10 pull_dn", pad_pull_dn, 32'h0000_0020);

    // R8 OUT/DIR drive pads, shared dir storage
    wr(6'd0, 32'hA5A5_0F0F);
    wr(6'd1, 32'hFFFF_0000);
    chk("R8 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R8 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(6'd48, v); chk("R8 CFG16 dir", v, 32'h1);
    cyc();
    wr(6'd35, 32'h01);
    rd(6'd1, v);  chk("R8 DIR via CFG3", v, 32'hFFFF_0008);

    // R9 override
    ovr_en = 32'h0000_00FF; ovr_out = 32'h55; ovr_oe = 32'h0F;
    #0.5;
    chk("R9 pad_out override", pad_out, 32'hA5A5_0F55);
    chk("R9 pad_oe override", pad_oe, 32'hFFFF_000F);
    ovr_en = '0;

    // R3 two-edge latency on pin 0
    wr(6'd32, 32'h02);
    pad_in[0] = 1'b1;
    cyc(); rd(6'd2, v); chk("R3 after one edge", v & 32'h1, 32'h0);
    cyc(); rd(6'd2, v); chk("R3 after two edges", v & 32'h1, 32'h1);
    pad_in[0] = 1'b0;

    // R4 disconnected pins with sense enabled
    wr(6'd39, 32'h20);
    wr(6'd40, 32'h30);
    pad_in[7] = 1'b1;
    repeat (5) cyc();
    rd(6'd2, v); chk("R4 disconnected reads 0", v & 32'h180, 32'h0);
    chk("R4 no detect", {31'b0, detect}, '0);

    // R5 sense-high rise timing on pin 9
    wr(6'd41, 32'h22);
    wr(6'd42, 32'h32);
    pad_in[10] = 1'b1;
    repeat (3) cyc();
    pad_in[9] = 1'b1;
    cyc(); cyc(); chk("R5 not yet at two edges", {31'b0, detect}, '0);
    cyc();        chk("R5 rise at third edge", {31'b0, detect}, 32'h1);

    // R6 hold and fall
    repeat (5) cyc();
    chk("R6 hold while active", {31'b0, detect}, 32'h1);
    pad_in[9] = 1'b0;
    cyc(); cyc(); chk("R6 still high", {31'b0, detect}, 32'h1);
    pad_in[9] = 1'b1;   // only two quiet samples follow
    cyc();        chk("R6 fall", {31'b0, detect}, 32'h0);

    // R7 short gap blocks a new event
    repeat (6) cyc();
    chk("R7 two quiet cycles not enough", {31'b0, detect}, 32'h0);
    pad_in[9] = 1'b0;
    repeat (3) cyc();
    pad_in[9] = 1'b1;
    cyc(); cyc(); chk("R7 window not yet", {31'b0, detect}, 32'h0);
    cyc();        chk("R7 fires after three quiet", {31'b0, detect}, 32'h1);

    // R5 sense-low on pin 10
    pad_in[9] = 1'b0;
    repeat (10) cyc();
    chk("R5 settled low", {31'b0, detect}, 32'h0);
    pad_in[10] = 1'b0;
    cyc(); cyc(); cyc();
    chk("R5 sense-low rise", {31'b0, detect}, 32'h1);

    // random phase against the model
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      cyc();
      chk("R5 R6 R7 detect", {31'b0, detect}, {31'b0, m_det});
      chk("R8 R9 pad_out", pad_out, (ovr_en & ovr_out) | (~ovr_en & m_out));
      chk("R8 R9 pad_oe", pad_oe, (ovr_en & ovr_oe) | (~ovr_en & m_dirv()));
      pad_in  = pad_in ^ ($urandom & $urandom & $urandom & $urandom);
      ovr_en  = $urandom & $urandom;
      ovr_out = $urandom;
      ovr_oe  = $urandom;
      bus_sel = 1'b1;
      bus_addr = 6'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        bus_we = 1'b1;
        bus_wdata = $urandom;
      end else begin
        bus_we = 1'b0;
        #0.5;
        chk("R2 R3 R4 read", bus_rdata, m_read(bus_addr));
      end
    end
    bus_sel = 1'b0; bus_we = 1'b0;
    cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule